// File: doc/BRIEF.md
# Hardware Loop Controller

This block sits beside the program counter of a DSP fetch unit and runs zero-overhead DO loops and single-instruction repeats. It owns three registers and a backup: the loop end address, the loop count with a spare copy for repeats, and the loop-active flag. It also contains the comparator that watches the current program address against the loop end. The decoder sends DO, ENDDO and REP commands as one-cycle pulses. Operands such as the count, the end address and the repeated instruction word arrive later, qualified by a data-valid strobe. The system stack lives outside the block. The controller asks for pushes and pulls and reads the top row as two halves.

When a loop body reaches its last address, the block signals one of two outcomes. On a continue it hands the loop start address from the stack top back to the fetch unit, without popping the row. On an end it unwinds the two saved stack rows and restores the outer loop context, so loops can nest. A repeat latches one instruction word and tells the decoder to reuse it for the requested number of cycles. During the repeat the outer loop counter is parked in a backup register.

In this block one instruction cycle is one clock. A DO must not directly follow another DO; at least one other cycle must separate them.

Top module: `hw_loop_ctrl`

## Requirements
- R1: When a DO takes its end-address operand, `la_q` holds that operand minus one from the next cycle on.
- R2: A count operand of zero loads `lc_q` with 16'hFFFF, for DO and for REP alike. While `loop_flag` is high, `lc_q` is never zero.
- R3: The comparator acts only in an idle cycle that carries no command, and only while `loop_flag` is 1. If `pc` equals `la_q`, it raises `loop_end` when `lc_q` is 1 and `loop_continue` when `lc_q` is above 1. The two are never high together.
- R4: On `loop_continue`, `loop_target` equals the high half of the stack top. There is no pull and no push in that cycle, and `lc_q` drops by one.
- R5: DO waits for two valid operands. With the first (the count), it pushes {high=`la_q`, low=`lc_q`} and loads the count into the loop counter. With the second, it pushes {high=`pc`, low=`sr_in`}. In the cycle after that, `loop_flag` becomes 1.
- R6: End processing takes two cycles, each with `pull_req`. The first sets `loop_flag` from bit 15 of the low half of the stack top. The second loads `la_q` from the high half and `lc_q` from the low half of the row below it.
- R7: An ENDDO while `loop_flag` is 1 starts the same end processing and raises `fetch_skip` in its second cycle. An end started by the comparator never raises `fetch_skip`.
- R8: An ENDDO while `loop_flag` is 0 is ignored: there is no pull, no `loop_end`, and no change of any register.
- R9: REP takes its count operand. It then copies `lc_q` to a backup, loads the count, and latches `insn_in`. For each count value from the loaded one down to 1 it raises `use_held` for one cycle, with `held_insn` equal to the latched word, and decrements `lc_q`. After the cycle at 1, `lc_q` returns to the backed-up value.
- R10: While `use_held` is high there is no `loop_continue`, no `loop_end`, no push and no pull.
- R11: After reset `la_q`, `lc_q`, `loop_flag`, `use_held`, `push_req` and `pull_req` are all zero.
- R12: `loop_end` is a one-cycle pulse in the idle cycle where end processing begins, and the next two cycles carry `pull_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_do | input | 1 | DO command pulse |
| cmd_enddo | input | 1 | ENDDO command pulse |
| cmd_rep | input | 1 | REP command pulse |
| opnd_valid | input | 1 | Operand strobe |
| opnd_data | input | W | Count or end-address operand |
| pc | input | W | Current program address |
| sr_in | input | W | Status word to save on DO |
| insn_in | input | IW | Instruction word to latch for REP |
| tos_hi | input | W | High half of the stack top row |
| tos_lo | input | W | Low half of the stack top row |
| push_req | output | 1 | Push a row this cycle |
| push_hi | output | W | High half of the pushed row |
| push_lo | output | W | Low half of the pushed row |
| pull_req | output | 1 | Pop the top row this cycle |
| loop_continue | output | 1 | Loop jumps back to its start |
| loop_end | output | 1 | Loop exit begins |
| loop_target | output | W | Restart address, valid with loop_continue |
| fetch_skip | output | 1 | Suppress the trailing fetch after ENDDO |
| use_held | output | 1 | Decoder takes held_insn instead of the fetched word |
| held_insn | output | IW | Latched repeat instruction |
| loop_flag | output | 1 | A DO loop is active |
| la_q | output | W | Loop end address register (stored minus one) |
| lc_q | output | W | Loop count register |

## Verification
The assertions rely on the decoder behaving as the sequencer expects. It sends commands only when the sequencer is idle, raises the operand strobe only while an operand is awaited, and never issues two DOs back to back. The stack must show the row below after each pull, so that the restore and flag checks read the right data. The stimulus meets these conditions with one stepping task that clears every command pulse after one clock. A bench-side queue plays the stack and answers the block's push and pull requests. The bench also keeps the program address off the loop end whenever the comparator is not meant to fire.

// File: rtl/hlc_pkg.sv
`timescale 1ns/1ps
package hlc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DO_CNT,
    ST_DO_ADR,
    ST_DO_FLAG,
    ST_END_FLAG,
    ST_END_REST,
    ST_REP_CNT,
    ST_REP_RUN
  } hlc_state_e;

  // Register update strobes from the sequencer to the register file
  typedef struct packed {
    logic push_save;   // save old end address / count, load new count
    logic push_ret;    // save return address / status, load end address
    logic set_lf;      // raise loop flag
    logic pull_flag;   // restore loop flag from saved status
    logic pull_rest;   // restore end address and count
    logic cont;        // another iteration
    logic rep_load;    // start a repeat
    logic rep_step;    // one repeat iteration
  } hlc_ctl_t;

endpackage

// File: rtl/hlc_cmp.sv
`timescale 1ns/1ps
module hlc_cmp #(
  parameter int W = 16
) (
  input  logic         enable,
  input  logic [W-1:0] pc,
  input  logic [W-1:0] la,
  input  logic [W-1:0] lc,
  output logic         hit_end,
  output logic         hit_cont
);

  localparam logic [W-1:0] ONE = W'(1);

  logic at_last;

  always_comb begin
    at_last  = enable && (pc == la);
    hit_end  = at_last && (lc == ONE);
    hit_cont = at_last && (lc >  ONE);
  end

endmodule

// File: rtl/hlc_seq.sv
`timescale 1ns/1ps
module hlc_seq
  import hlc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_do,
  input  logic     cmd_enddo,
  input  logic     cmd_rep,
  input  logic     opnd_valid,
  input  logic     lf,
  input  logic     hit_end,
  input  logic     hit_cont,
  input  logic     lc_one,
  output hlc_ctl_t ctl,
  output logic     cmp_en,
  output logic     loop_end,
  output logic     fetch_skip,
  output logic     use_held
);

  hlc_state_e st_q, st_d;
  logic       by_cmd_q, by_cmd_d;

  // next-state and strobe decode
  always_comb begin
    st_d       = st_q;
    by_cmd_d   = by_cmd_q;
    ctl        = '0;
    loop_end   = 1'b0;
    fetch_skip = 1'b0;
    use_held   = 1'b0;
    cmp_en     = (st_q == ST_IDLE) && !cmd_do && !cmd_rep && !cmd_enddo;

    case (st_q)
      ST_IDLE: begin
        if (cmd_do) begin
          st_d = ST_DO_CNT;
        end else if (cmd_rep) begin
          st_d = ST_REP_CNT;
        end else if (cmd_enddo) begin
          if (lf) begin
            st_d     = ST_END_FLAG;
            by_cmd_d = 1'b1;
            loop_end = 1'b1;
          end
        end else if (hit_end) begin
          st_d     = ST_END_FLAG;
          by_cmd_d = 1'b0;
          loop_end = 1'b1;
        end else if (hit_cont) begin
          ctl.cont = 1'b1;
        end
      end
      ST_DO_CNT: begin
        if (opnd_valid) begin
          ctl.push_save = 1'b1;
          st_d          = ST_DO_ADR;
        end
      end
      ST_DO_ADR: begin
        if (opnd_valid) begin
          ctl.push_ret = 1'b1;
          st_d         = ST_DO_FLAG;
        end
      end
      ST_DO_FLAG: begin
        ctl.set_lf = 1'b1;
        st_d       = ST_IDLE;
      end
      ST_END_FLAG: begin
        ctl.pull_flag = 1'b1;
        st_d          = ST_END_REST;
      end
      ST_END_REST: begin
        ctl.pull_rest = 1'b1;
        fetch_skip    = by_cmd_q;
        st_d          = ST_IDLE;
      end
      ST_REP_CNT: begin
        if (opnd_valid) begin
          ctl.rep_load = 1'b1;
          st_d         = ST_REP_RUN;
        end
      end
      ST_REP_RUN: begin
        use_held     = 1'b1;
        ctl.rep_step = 1'b1;
        if (lc_one) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      by_cmd_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      by_cmd_q <= by_cmd_d;
    end
  end

endmodule

// File: rtl/hlc_regs.sv
`timescale 1ns/1ps
module hlc_regs
  import hlc_pkg::*;
#(
  parameter int W      = 16,
  parameter int IW     = 24,
  parameter int LF_POS = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hlc_ctl_t      ctl,
  input  logic          lc_one,
  input  logic [W-1:0]  opnd_data,
  input  logic [W-1:0]  tos_hi,
  input  logic [W-1:0]  tos_lo,
  input  logic [IW-1:0] insn_in,
  output logic [W-1:0]  la_q,
  output logic [W-1:0]  lc_q,
  output logic          lf_q,
  output logic [IW-1:0] held_q
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0]  la_d, lc_d, bak_q, cnt_fix;
  logic          la_en, lc_en, lf_en, lf_d, rep_en;

  // a zero count means the full range
  always_comb begin
    cnt_fix = (opnd_data == '0) ? '1 : opnd_data;
  end

  always_comb begin
    la_en = ctl.push_ret || ctl.pull_rest;
    la_d  = ctl.push_ret ? (opnd_data - ONE) : tos_hi;
  end

  always_comb begin
    lc_en = ctl.push_save || ctl.rep_load || ctl.cont ||
            ctl.rep_step  || ctl.pull_rest;
    if (ctl.push_save || ctl.rep_load) begin
      lc_d = cnt_fix;
    end else if (ctl.pull_rest) begin
      lc_d = tos_lo;
    end else if (ctl.rep_step && lc_one) begin
      lc_d = bak_q;
    end else begin
      lc_d = lc_q - ONE;
    end
  end

  always_comb begin
    lf_en  = ctl.set_lf || ctl.pull_flag;
    lf_d   = ctl.set_lf ? 1'b1 : tos_lo[LF_POS];
    rep_en = ctl.rep_load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      la_q <= '0;
    end else if (la_en) begin
      la_q <= la_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q <= '0;
    end else if (lc_en) begin
      lc_q <= lc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lf_q <= 1'b0;
    end else if (lf_en) begin
      lf_q <= lf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bak_q  <= '0;
      held_q <= '0;
    end else if (rep_en) begin
      bak_q  <= lc_q;
      held_q <= insn_in;
    end
  end

endmodule

// File: rtl/hw_loop_ctrl.sv
`timescale 1ns/1ps
module hw_loop_ctrl
  import hlc_pkg::*;
#(
  parameter int W      = 16,
  parameter int IW     = 24,
  parameter int LF_POS = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_do,
  input  logic          cmd_enddo,
  input  logic          cmd_rep,
  input  logic          opnd_valid,
  input  logic [W-1:0]  opnd_data,
  input  logic [W-1:0]  pc,
  input  logic [W-1:0]  sr_in,
  input  logic [IW-1:0] insn_in,
  input  logic [W-1:0]  tos_hi,
  input  logic [W-1:0]  tos_lo,
  output logic          push_req,
  output logic [W-1:0]  push_hi,
  output logic [W-1:0]  push_lo,
  output logic          pull_req,
  output logic          loop_continue,
  output logic          loop_end,
  output logic [W-1:0]  loop_target,
  output logic          fetch_skip,
  output logic          use_held,
  output logic [IW-1:0] held_insn,
  output logic          loop_flag,
  output logic [W-1:0]  la_q,
  output logic [W-1:0]  lc_q
);

  localparam logic [W-1:0] ONE = W'(1);

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  hlc_ctl_t ctl;
  logic     cmp_en, hit_end, hit_cont, lc_one;

  assign lc_one = (lc_q == ONE);

  hlc_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .cmd_do     (cmd_do),
    .cmd_enddo  (cmd_enddo),
    .cmd_rep    (cmd_rep),
    .opnd_valid (opnd_valid),
    .lf         (loop_flag),
    .hit_end    (hit_end),
    .hit_cont   (hit_cont),
    .lc_one     (lc_one),
    .ctl        (ctl),
    .cmp_en     (cmp_en),
    .loop_end   (loop_end),
    .fetch_skip (fetch_skip),
    .use_held   (use_held)
  );

  hlc_cmp #(.W(W)) u_cmp (
    .enable   (cmp_en && loop_flag),
    .pc       (pc),
    .la       (la_q),
    .lc       (lc_q),
    .hit_end  (hit_end),
    .hit_cont (hit_cont)
  );

  hlc_regs #(.W(W), .IW(IW), .LF_POS(LF_POS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ctl       (ctl),
    .lc_one    (lc_one),
    .opnd_data (opnd_data),
    .tos_hi    (tos_hi),
    .tos_lo    (tos_lo),
    .insn_in   (insn_in),
    .la_q      (la_q),
    .lc_q      (lc_q),
    .lf_q      (loop_flag),
    .held_q    (held_insn)
  );

  // stack traffic
  always_comb begin
    push_req      = ctl.push_save || ctl.push_ret;
    push_hi       = ctl.push_save ? la_q : pc;
    push_lo       = ctl.push_save ? lc_q : sr_in;
    pull_req      = ctl.pull_flag || ctl.pull_rest;
    loop_continue = ctl.cont;
    loop_target   = tos_hi;
  end

endmodule

// File: rtl/hw_loop_ctrl_chk.sv
`timescale 1ns/1ps
module hw_loop_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         loop_continue,
  input logic         loop_end,
  input logic         push_req,
  input logic         pull_req,
  input logic         use_held,
  input logic         fetch_skip,
  input logic         loop_flag,
  input logic [W-1:0] lc_q
);

  p_cont_end_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(loop_continue && loop_end));

  p_cont_no_stack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_continue |-> (!pull_req && !push_req));

  p_cont_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_continue |=> (lc_q == $past(lc_q) - W'(1)));

  p_end_first_pull_r12: assert property (@(posedge clk) disable iff (!rst_n)
    loop_end |=> pull_req);

  p_end_second_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(loop_end, 2) |-> pull_req);

  p_rep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    use_held |-> (!loop_continue && !loop_end && !push_req && !pull_req));

  p_skip_in_unwind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_skip |-> pull_req);

  p_flag_count_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_flag |-> (lc_q != '0));

endmodule

bind hw_loop_ctrl hw_loop_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/hw_loop_ctrl_tb.sv
`timescale 1ns/1ps
module hw_loop_ctrl_tb_top;

  localparam int W  = 16;
  localparam int IW = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_do, cmd_enddo, cmd_rep, opnd_valid;
  logic [W-1:0]  opnd_data, pc, sr_in, tos_hi, tos_lo;
  logic [IW-1:0] insn_in;
  logic          push_req, pull_req, loop_continue, loop_end, fetch_skip;
  logic          use_held, loop_flag;
  logic [W-1:0]  push_hi, push_lo, loop_target, la_q, lc_q;
  logic [IW-1:0] held_insn;

  always #5 clk = ~clk;

  hw_loop_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_do(cmd_do), .cmd_enddo(cmd_enddo),
    .cmd_rep(cmd_rep), .opnd_valid(opnd_valid), .opnd_data(opnd_data),
    .pc(pc), .sr_in(sr_in), .insn_in(insn_in), .tos_hi(tos_hi),
    .tos_lo(tos_lo), .push_req(push_req), .push_hi(push_hi),
    .push_lo(push_lo), .pull_req(pull_req), .loop_continue(loop_continue),
    .loop_end(loop_end), .loop_target(loop_target), .fetch_skip(fetch_skip),
    .use_held(use_held), .held_insn(held_insn), .loop_flag(loop_flag),
    .la_q(la_q), .lc_q(lc_q)
  );

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // stack environment
  logic [31:0] stk[$];
  logic        pend_push, pend_pull;
  logic [31:0] pend_row;

  // reference model state
  int            m_st;
  logic [W-1:0]  m_la, m_lc, m_bak;
  logic          m_lf, m_byc;
  logic [IW-1:0] m_held;

  // last sampled outputs
  logic last_cont, last_end, last_skip, last_use, last_pull, last_push;
  logic [W-1:0] last_target;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] fix(logic [W-1:0] v);
    return (v == '0) ? '1 : v;
  endfunction

  task automatic refresh_tos();
    if (stk.size() > 0) begin
      tos_hi = stk[stk.size()-1][31:16];
      tos_lo = stk[stk.size()-1][15:0];
    end else begin
      tos_hi = '0;
      tos_lo = '0;
    end
  endtask

  task automatic model_cycle();
    logic e_push, e_pull, e_cont, e_end, e_skip, e_use;
    logic [W-1:0] e_hi, e_lo;
    int n_st;
    logic [W-1:0] n_la, n_lc, n_bak;
    logic n_lf, n_byc;
    logic [IW-1:0] n_held;
    e_push = 0; e_pull = 0; e_cont = 0; e_end = 0; e_skip = 0; e_use = 0;
    e_hi = '0; e_lo = '0;
    n_st = m_st; n_la = m_la; n_lc = m_lc; n_bak = m_bak; n_lf = m_lf;
    n_byc = m_byc; n_held = m_held;
    case (m_st)
      0: begin
        if (cmd_do) n_st = 1;
        else if (cmd_rep) n_st = 6;
        else if (cmd_enddo) begin
          if (m_lf) begin n_st = 4; n_byc = 1; e_end = 1; end
        end else if (m_lf && pc == m_la) begin
          if (m_lc == 1) begin e_end = 1; n_st = 4; n_byc = 0; end
          else if (m_lc > 1) begin e_cont = 1; n_lc = m_lc - 1; end
        end
      end
      1: if (opnd_valid) begin
        e_push = 1; e_hi = m_la; e_lo = m_lc; n_lc = fix(opnd_data); n_st = 2;
      end
      2: if (opnd_valid) begin
        e_push = 1; e_hi = pc; e_lo = sr_in; n_la = opnd_data - 1; n_st = 3;
      end
      3: begin n_lf = 1; n_st = 0; end
      4: begin e_pull = 1; n_lf = tos_lo[15]; n_st = 5; end
      5: begin
        e_pull = 1; n_la = tos_hi; n_lc = tos_lo; e_skip = m_byc; n_st = 0;
      end
      6: if (opnd_valid) begin
        n_bak = m_lc; n_lc = fix(opnd_data); n_held = insn_in; n_st = 7;
      end
      default: begin
        e_use = 1;
        if (m_lc == 1) begin n_lc = m_bak; n_st = 0; end
        else n_lc = m_lc - 1;
      end
    endcase
    chk("R5 push_req", push_req, e_push);
    if (e_push) begin
      chk("R5 push_hi", push_hi, e_hi);
      chk("R5 push_lo", push_lo, e_lo);
    end
    chk("R6 pull_req", pull_req, e_pull);
    chk("R3 loop_continue", loop_continue, e_cont);
    chk("R12 loop_end", loop_end, e_end);
    chk("R7 fetch_skip", fetch_skip, e_skip);
    chk("R9 use_held", use_held, e_use);
    if (e_cont) chk("R4 loop_target", loop_target, tos_hi);
    if (e_use) chk("R9 held_insn", held_insn, m_held);
    chk("R1 la_q", la_q, m_la);
    chk("R2 lc_q", lc_q, m_lc);
    chk("R6 loop_flag", loop_flag, m_lf);
    last_cont = loop_continue; last_end = loop_end; last_skip = fetch_skip;
    last_use = use_held; last_pull = pull_req; last_push = push_req;
    last_target = loop_target;
    pend_push = push_req; pend_pull = pull_req; pend_row = {push_hi, push_lo};
    m_st = n_st; m_la = n_la; m_lc = n_lc; m_bak = n_bak; m_lf = n_lf;
    m_byc = n_byc; m_held = n_held;
  endtask

  task automatic step();
    @(negedge clk);
    model_cycle();
    @(posedge clk);
    #1;
    if (pend_push) stk.push_back(pend_row);
    if (pend_pull && stk.size() > 0) stk.delete(stk.size()-1);
    refresh_tos();
    cmd_do = 0; cmd_enddo = 0; cmd_rep = 0; opnd_valid = 0;
    sr_in = {m_lf, 15'h00A5};
  endtask

  task automatic start_do(logic [W-1:0] cnt, logic [W-1:0] last_addr,
                          logic [W-1:0] start_pc);
    pc = start_pc; cmd_do = 1; step();
    step();                                  // count not yet valid: waits
    opnd_valid = 1; opnd_data = cnt; step();
    opnd_valid = 1; opnd_data = last_addr; step();
    step();
  endtask

  task automatic at_pc(logic [W-1:0] a);
    pc = a; step();
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int uses;
    rst_n = 0; cmd_do = 0; cmd_enddo = 0; cmd_rep = 0; opnd_valid = 0;
    opnd_data = '0; pc = 16'h0050; sr_in = 16'h00A5; insn_in = '0;
    tos_hi = '0; tos_lo = '0;
    m_st = 0; m_la = '0; m_lc = '0; m_bak = '0; m_lf = 0; m_byc = 0; m_held = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R11: reset state
    chk("R11 la_q", la_q, 0);
    chk("R11 lc_q", lc_q, 0);
    chk("R11 loop_flag", loop_flag, 0);
    chk("R11 use_held", use_held, 0);
    chk("R11 push_req", push_req, 0);
    chk("R11 pull_req", pull_req, 0);

    // single loop, three passes
    start_do(16'd3, 16'h0105, 16'h0100);
    chk("R1 la minus one", la_q, 16'h0104);
    chk("R5 count loaded", lc_q, 16'd3);
    chk("R5 flag set", loop_flag, 1);
    at_pc(16'h0101); at_pc(16'h0102); at_pc(16'h0103);
    at_pc(16'h0104);
    chk("R4 continue seen", last_cont, 1);
    chk("R4 target is start", last_target, 16'h0100);
    chk("R4 count down", lc_q, 16'd2);
    at_pc(16'h0100); at_pc(16'h0104);
    chk("R3 second continue", last_cont, 1);
    at_pc(16'h0104);
    chk("R3 end at count one", last_end, 1);
    pc = 16'h0106; step();
    chk("R6 flag restored clear", loop_flag, 0);
    step();
    chk("R7 no skip on comparator end", last_skip, 0);
    chk("R6 la restored", la_q, 0);
    chk("R6 lc restored", lc_q, 0);

    // R8: ENDDO with no active loop
    cmd_enddo = 1; step();
    chk("R8 no end", last_end, 0);
    step();
    chk("R8 no pull", last_pull, 0);
    chk("R8 flag still clear", loop_flag, 0);

    // R2 zero count, R7 ENDDO exit
    start_do(16'd0, 16'h0301, 16'h0300);
    chk("R2 zero count", lc_q, 16'hFFFF);
    pc = 16'h0301;
    cmd_enddo = 1; step();
    chk("R7 enddo starts end", last_end, 1);
    step(); step();
    chk("R7 skip on enddo", last_skip, 1);
    chk("R7 flag clear", loop_flag, 0);

    // nested loops with a repeat inside
    start_do(16'd2, 16'h0210, 16'h0200);
    at_pc(16'h0201);
    start_do(16'd2, 16'h020A, 16'h0202);
    chk("R1 inner la", la_q, 16'h0209);
    at_pc(16'h0209);
    at_pc(16'h0209);
    chk("R3 inner end", last_end, 1);
    pc = 16'h020B; step(); step();
    chk("R6 outer flag kept", loop_flag, 1);
    chk("R6 outer la", la_q, 16'h020F);
    chk("R6 outer lc", lc_q, 16'd2);
    cmd_rep = 1; step();
    opnd_valid = 1; opnd_data = 16'd3; insn_in = 24'hABCDEF; step();
    uses = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (last_use) uses++;
      else break;
    end
    chk("R9 repeat uses", uses, 3);
    chk("R9 lc back", lc_q, 16'd2);
    cmd_rep = 1; step();
    opnd_valid = 1; opnd_data = 16'd1; insn_in = 24'h123456; step();
    step();
    chk("R9 single repeat", last_use, 1);
    step();
    chk("R9 single done", last_use, 0);
    at_pc(16'h020F);
    chk("R4 outer continue", last_cont, 1);
    chk("R4 outer target", last_target, 16'h0200);
    at_pc(16'h020F);
    chk("R12 outer end", last_end, 1);
    pc = 16'h0211; step(); step();
    chk("R6 all clear", loop_flag, 0);

    // R2 on repeat: zero count gives 65535 uses
    cmd_rep = 1; step();
    opnd_valid = 1; opnd_data = 16'd0; insn_in = 24'h0F0F0F; step();
    chk("R2 rep zero count", lc_q, 16'hFFFF);
    uses = 0;
    for (int i = 0; i < 70000; i++) begin
      step();
      if (last_use) uses++;
      else break;
    end
    chk("R2 rep zero uses", uses, 65535);
    chk("R9 lc restored after long repeat", lc_q, 16'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule